// File: doc/BRIEF.md
# RV64 Instruction Legality Checker

This block sits beside the decode stage of a 64-bit RISC-V style core. Each cycle it takes one 32-bit instruction word and reports two things: the opcode class the word belongs to, and whether the word must trap as an illegal instruction. The policy is strict. A word is legal only if its encoding is defined for its class. Undefined funct fields, shift amounts wider than the operation, and unknown major opcodes all raise the trap flag.

The core treats memory-ordering words as no-operations, so the checker only confirms that they are well formed. Two parameters select the variant. `XLEN` chooses the 64-bit or the 32-bit rule set; in the 32-bit set the word-operation classes become unknown. `OUT_REG` chooses between a registered result with one cycle of latency and a purely combinational result.

Top module: `insn_legality_check`

## Requirements
- R1: A word whose bits [1:0] are not 2'b11 reports class 0 (none) with the trap flag set.
- R2: Class codes follow the major opcode in bits [6:0]: none=0, load (0000011)=1, store (0100011)=2, OP (0110011)=3, OP-IMM (0010011)=4, OP-32 (0111011)=5, OP-IMM-32 (0011011)=6, SYSTEM (1110011)=7, MISC-MEM (0001111)=8, AUIPC (0010111)=9, LUI (0110111)=10, JAL (1101111)=11, JALR (1100111)=12.
- R3: A load traps only when funct3 (bits [14:12]) is 111.
- R4: A store traps when funct3 is 100 or above.
- R5: In OP, funct7 (bits [31:25]) of 0000000 is legal with any funct3, and 0100000 is legal only with funct3 000 or 101. Any other funct7 traps.
- R6: With XLEN=64, OP-IMM with funct3 001 needs bits [31:26]=000000. With funct3 101 it needs 000000 or 010000. Other funct3 values accept any immediate.
- R7: OP-IMM-32 accepts funct3 000 with any immediate, funct3 001 with funct7 0000000, and funct3 101 with funct7 0000000 or 0100000. A set bit 25 (a shift of 32 or more) traps, and so does any other funct3.
- R8: OP-32 accepts funct3 000 and 101 with funct7 0000000 or 0100000, and funct3 001 with funct7 0000000. Everything else traps.
- R9: In SYSTEM, funct3 100 traps. Funct3 000 is legal only for these exact words: 0x00000073, 0x00100073, 0x10200073, 0x30200073 and 0x10500073. The remaining funct3 values, which are the CSR read-modify-write forms, are legal.
- R10: MISC-MEM is legal only with funct3 000 or 001.
- R11: LUI, AUIPC and JAL never trap. JALR traps unless funct3 is 000.
- R12: A major opcode outside the list in R2 reports class 0 with the trap flag set.
- R13: With OUT_REG=1, both outputs show the result for the word sampled at the previous rising clock edge. While rst_ni is low they show class 0 with the trap flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| insn_i | input | 32 | Instruction word to classify |
| class_o | output | 4 | Opcode class code, per R2 |
| illegal_o | output | 1 | Illegal-instruction trap flag |

## Verification
The only state is the output register, so a fault there shows at the ports one cycle after the word that exposes it. Such a fault would be a stale result, a reset value that leaks through, or a flag paired with the wrong class. Faults in the per-class rules show up only for particular field patterns. For that reason the stimulus sits on each side of every boundary: shift bit 25, the funct3 cut-offs for loads and stores, and the exact SYSTEM words. A rule that is wrong then flips the trap flag on the very next cycle.

// File: rtl/insn_chk_pkg.sv
package insn_chk_pkg;

    typedef enum logic [3:0] {
        CLS_NONE    = 4'd0,
        CLS_LOAD    = 4'd1,
        CLS_STORE   = 4'd2,
        CLS_OP      = 4'd3,
        CLS_OPIMM   = 4'd4,
        CLS_OP32    = 4'd5,
        CLS_OPIMM32 = 4'd6,
        CLS_SYSTEM  = 4'd7,
        CLS_MISCMEM = 4'd8,
        CLS_AUIPC   = 4'd9,
        CLS_LUI     = 4'd10,
        CLS_JAL     = 4'd11,
        CLS_JALR    = 4'd12
    } insn_cls_e;

    localparam logic [6:0] OPC_LOAD    = 7'b0000011;
    localparam logic [6:0] OPC_STORE   = 7'b0100011;
    localparam logic [6:0] OPC_OP      = 7'b0110011;
    localparam logic [6:0] OPC_OPIMM   = 7'b0010011;
    localparam logic [6:0] OPC_OP32    = 7'b0111011;
    localparam logic [6:0] OPC_OPIMM32 = 7'b0011011;
    localparam logic [6:0] OPC_SYSTEM  = 7'b1110011;
    localparam logic [6:0] OPC_MISCMEM = 7'b0001111;
    localparam logic [6:0] OPC_AUIPC   = 7'b0010111;
    localparam logic [6:0] OPC_LUI     = 7'b0110111;
    localparam logic [6:0] OPC_JAL     = 7'b1101111;
    localparam logic [6:0] OPC_JALR    = 7'b1100111;

    typedef struct packed {
        insn_cls_e cls;
        logic      illegal;
    } chk_res_t;

endpackage

// File: rtl/insn_class_decode.sv
module insn_class_decode
    import insn_chk_pkg::*;
#(
    parameter bit IS64 = 1'b1
) (
    input  logic [6:0] opcode_i,
    output insn_cls_e  cls_o
);

    always_comb begin
        unique case (opcode_i)
            OPC_LOAD:    cls_o = CLS_LOAD;
            OPC_STORE:   cls_o = CLS_STORE;
            OPC_OP:      cls_o = CLS_OP;
            OPC_OPIMM:   cls_o = CLS_OPIMM;
            OPC_OP32:    cls_o = IS64 ? CLS_OP32 : CLS_NONE;
            OPC_OPIMM32: cls_o = IS64 ? CLS_OPIMM32 : CLS_NONE;
            OPC_SYSTEM:  cls_o = CLS_SYSTEM;
            OPC_MISCMEM: cls_o = CLS_MISCMEM;
            OPC_AUIPC:   cls_o = CLS_AUIPC;
            OPC_LUI:     cls_o = CLS_LUI;
            OPC_JAL:     cls_o = CLS_JAL;
            OPC_JALR:    cls_o = CLS_JALR;
            default:     cls_o = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/insn_class_rules.sv
module insn_class_rules
    import insn_chk_pkg::*;
#(
    parameter bit IS64 = 1'b1
) (
    input  logic [31:7] fields_i,
    input  insn_cls_e   cls_i,
    output logic        legal_o
);

    logic [6:0] f7;
    logic [4:0] rs2;
    logic [4:0] rs1;
    logic [2:0] f3;
    logic [4:0] rd;
    logic [11:0] sys_imm;
    logic        f7_zero;
    logic        f7_alt;
    logic        sys_word_ok;
    logic        opimm_shl_ok;
    logic        opimm_shr_ok;

    assign f7      = fields_i[31:25];
    assign rs2     = fields_i[24:20];
    assign rs1     = fields_i[19:15];
    assign f3      = fields_i[14:12];
    assign rd      = fields_i[11:7];
    assign sys_imm = {f7, rs2};
    assign f7_zero = (f7 == 7'b0000000);
    assign f7_alt  = (f7 == 7'b0100000);

    // environment call, breakpoint, supervisor/machine trap return, wait
    always_comb begin
        sys_word_ok = (rd == 5'd0) && (rs1 == 5'd0) &&
                      ((sys_imm == 12'h000) || (sys_imm == 12'h001) ||
                       (sys_imm == 12'h102) || (sys_imm == 12'h302) ||
                       (sys_imm == 12'h105));
    end

    // shift-immediate width depends on the machine width
    generate
        if (IS64) begin : g_shamt6
            assign opimm_shl_ok = (f7[6:1] == 6'b000000);
            assign opimm_shr_ok = (f7[6:1] == 6'b000000) ||
                                  (f7[6:1] == 6'b010000);
        end else begin : g_shamt5
            assign opimm_shl_ok = f7_zero;
            assign opimm_shr_ok = f7_zero || f7_alt;
        end
    endgenerate

    always_comb begin
        legal_o = 1'b0;
        unique case (cls_i)
            CLS_LOAD:    legal_o = (f3 != 3'b111);
            CLS_STORE:   legal_o = (f3[2] == 1'b0);
            CLS_OP:      legal_o = f7_zero ||
                                   (f7_alt && ((f3 == 3'b000) || (f3 == 3'b101)));
            CLS_OPIMM: begin
                if (f3 == 3'b001)      legal_o = opimm_shl_ok;
                else if (f3 == 3'b101) legal_o = opimm_shr_ok;
                else                   legal_o = 1'b1;
            end
            CLS_OPIMM32: begin
                unique case (f3)
                    3'b000:  legal_o = 1'b1;
                    3'b001:  legal_o = f7_zero;
                    3'b101:  legal_o = f7_zero || f7_alt;
                    default: legal_o = 1'b0;
                endcase
            end
            CLS_OP32: begin
                unique case (f3)
                    3'b000, 3'b101: legal_o = f7_zero || f7_alt;
                    3'b001:         legal_o = f7_zero;
                    default:        legal_o = 1'b0;
                endcase
            end
            CLS_SYSTEM: begin
                if (f3 == 3'b000)      legal_o = sys_word_ok;
                else if (f3 == 3'b100) legal_o = 1'b0;
                else                   legal_o = 1'b1;
            end
            CLS_MISCMEM: legal_o = (f3[2:1] == 2'b00);
            CLS_AUIPC,
            CLS_LUI,
            CLS_JAL:     legal_o = 1'b1;
            CLS_JALR:    legal_o = (f3 == 3'b000);
            default:     legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/insn_legality_check.sv
module insn_legality_check
    import insn_chk_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [31:0] insn_i,
    output logic [3:0]  class_o,
    output logic        illegal_o
);

    localparam bit IS64 = (XLEN == 64);

    insn_cls_e cls;
    logic      legal;
    chk_res_t  res_d;
    chk_res_t  res_q;

    insn_class_decode #(
        .IS64 (IS64)
    ) i_decode (
        .opcode_i (insn_i[6:0]),
        .cls_o    (cls)
    );

    insn_class_rules #(
        .IS64 (IS64)
    ) i_rules (
        .fields_i (insn_i[31:7]),
        .cls_i    (cls),
        .legal_o  (legal)
    );

    always_comb begin
        res_d.cls     = cls;
        res_d.illegal = (cls == CLS_NONE) || !legal;
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    res_q <= '{cls: CLS_NONE, illegal: 1'b0};
                end else begin
                    res_q <= res_d;
                end
            end
        end else begin : g_comb
            assign res_q = res_d;
        end
    endgenerate

    assign class_o   = res_q.cls;
    assign illegal_o = res_q.illegal;

endmodule

// File: rtl/insn_legality_check_sva.sv
module insn_legality_check_sva
    import insn_chk_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [31:0] insn_i,
    input logic [3:0]  class_o,
    input logic        illegal_o
);

    logic [31:0] ref_insn;
    logic        ref_ok;

    generate
        if (OUT_REG) begin : g_lag
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    ref_insn <= '0;
                    ref_ok   <= 1'b0;
                end else begin
                    ref_insn <= insn_i;
                    ref_ok   <= 1'b1;
                end
            end
        end else begin : g_now
            assign ref_insn = insn_i;
            assign ref_ok   = 1'b1;
        end
    endgenerate

    assert_compressed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_ok && ref_insn[1:0] != 2'b11) |-> (illegal_o && class_o == CLS_NONE));

    assert_load_f3_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_ok && ref_insn[6:0] == OPC_LOAD) |->
        (class_o == CLS_LOAD && illegal_o == (ref_insn[14:12] == 3'b111)));

    assert_store_f3_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_ok && ref_insn[6:0] == OPC_STORE) |->
        (class_o == CLS_STORE && illegal_o == ref_insn[14]));

    assert_word_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_ok && ref_insn[6:0] == OPC_OPIMM32 && ref_insn[14:12] == 3'b001 &&
         ref_insn[25]) |-> illegal_o);

    assert_upper_legal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_ok && (class_o == CLS_LUI || class_o == CLS_AUIPC || class_o == CLS_JAL))
        |-> !illegal_o);

    assert_none_traps_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_ok && class_o == CLS_NONE) |-> illegal_o);

endmodule

bind insn_legality_check insn_legality_check_sva #(
    .OUT_REG (OUT_REG)
) i_sva (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .insn_i    (insn_i),
    .class_o   (class_o),
    .illegal_o (illegal_o)
);

// File: tb/test_insn_legality_check.sv
module test_insn_legality_check;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_ni;
    logic [31:0] insn_i;
    logic [3:0]  class_o;
    logic        illegal_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    insn_legality_check #(
        .XLEN    (64),
        .OUT_REG (1'b1)
    ) i_insn_legality_check (
        .clk_i     (clk),
        .rst_ni    (rst_ni),
        .insn_i    (insn_i),
        .class_o   (class_o),
        .illegal_o (illegal_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] enc(int f7, int rs2, int rs1, int f3, int rd, int op);
        logic [31:0] w;
        w = {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], op[6:0]};
        return w;
    endfunction

    typedef struct packed {
        logic [31:0] insn;
        logic [3:0]  cls;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 43;

    // class codes per R2; each entry names its requirement
    localparam vec_t VECS [NVEC] = '{
        '{enc(0, 0, 1, 3, 2, 'h03),        4'd1,  1'b0, 4'd3},   // R3 doubleword load
        '{enc(0, 0, 1, 6, 2, 'h03),        4'd1,  1'b0, 4'd3},   // R3 unsigned word load
        '{enc(0, 0, 1, 7, 2, 'h03),        4'd1,  1'b1, 4'd3},   // R3 funct3 111
        '{enc(0, 4, 1, 3, 2, 'h23),        4'd2,  1'b0, 4'd4},   // R4 doubleword store
        '{enc(0, 4, 1, 4, 2, 'h23),        4'd2,  1'b1, 4'd4},   // R4 funct3 100
        '{enc('h7F, 4, 1, 7, 2, 'h23),     4'd2,  1'b1, 4'd4},   // R4 funct3 111
        '{enc(0, 3, 2, 0, 1, 'h33),        4'd3,  1'b0, 4'd5},   // R5 add
        '{enc('h20, 3, 2, 0, 1, 'h33),     4'd3,  1'b0, 4'd5},   // R5 sub
        '{enc('h20, 3, 2, 5, 1, 'h33),     4'd3,  1'b0, 4'd5},   // R5 sra
        '{enc('h20, 3, 2, 1, 1, 'h33),     4'd3,  1'b1, 4'd5},   // R5 alt funct7 on sll
        '{enc(1, 3, 2, 0, 1, 'h33),        4'd3,  1'b1, 4'd5},   // R5 funct7 0000001
        '{enc('h7F, 'h1F, 2, 0, 1, 'h13),  4'd4,  1'b0, 4'd6},   // R6 addi any imm
        '{enc(1, 'h1F, 2, 1, 1, 'h13),     4'd4,  1'b0, 4'd6},   // R6 left shift by 63
        '{enc('h20, 1, 2, 1, 1, 'h13),     4'd4,  1'b1, 4'd6},   // R6 left shift alt bits
        '{enc('h21, 'h1F, 2, 5, 1, 'h13),  4'd4,  1'b0, 4'd6},   // R6 arith right by 63
        '{enc(2, 0, 2, 5, 1, 'h13),        4'd4,  1'b1, 4'd6},   // R6 bad upper bits
        '{enc('h7F, 'h1F, 2, 0, 1, 'h1B),  4'd6,  1'b0, 4'd7},   // R7 addiw any imm
        '{enc(1, 0, 2, 1, 1, 'h1B),        4'd6,  1'b1, 4'd7},   // R7 word shift by 32
        '{enc('h20, 'h1F, 2, 5, 1, 'h1B),  4'd6,  1'b0, 4'd7},   // R7 word arith by 31
        '{enc('h21, 0, 2, 5, 1, 'h1B),     4'd6,  1'b1, 4'd7},   // R7 word arith by 32
        '{enc(0, 0, 2, 2, 1, 'h1B),        4'd6,  1'b1, 4'd7},   // R7 funct3 010
        '{enc('h20, 3, 2, 0, 1, 'h3B),     4'd5,  1'b0, 4'd8},   // R8 subw
        '{enc('h20, 3, 2, 1, 1, 'h3B),     4'd5,  1'b1, 4'd8},   // R8 alt funct7 on sllw
        '{enc(0, 3, 2, 4, 1, 'h3B),        4'd5,  1'b1, 4'd8},   // R8 funct3 100
        '{enc(0, 3, 2, 5, 1, 'h3B),        4'd5,  1'b0, 4'd8},   // R8 srlw
        '{enc(0, 0, 0, 0, 0, 'h73),        4'd7,  1'b0, 4'd9},   // R9 env call
        '{enc(0, 1, 0, 0, 0, 'h73),        4'd7,  1'b0, 4'd9},   // R9 breakpoint
        '{enc('h18, 2, 0, 0, 0, 'h73),     4'd7,  1'b0, 4'd9},   // R9 machine return
        '{enc(0, 0, 0, 0, 1, 'h73),        4'd7,  1'b1, 4'd9},   // R9 env call with rd
        '{enc(0, 0, 0, 4, 0, 'h73),        4'd7,  1'b1, 4'd9},   // R9 funct3 100
        '{enc('h18, 0, 5, 1, 3, 'h73),     4'd7,  1'b0, 4'd9},   // R9 csr swap
        '{enc(0, 0, 0, 0, 0, 'h0F),        4'd8,  1'b0, 4'd10},  // R10 fence
        '{enc(0, 0, 0, 2, 0, 'h0F),        4'd8,  1'b1, 4'd10},  // R10 funct3 010
        '{enc('h55, 'h0A, 3, 5, 7, 'h37),  4'd10, 1'b0, 4'd11},  // R11 lui
        '{enc('h55, 'h0A, 3, 5, 7, 'h17),  4'd9,  1'b0, 4'd11},  // R11 auipc
        '{enc('h7F, 'h1F, 'h1F, 7, 1, 'h6F), 4'd11, 1'b0, 4'd11}, // R11 jal
        '{enc(0, 0, 1, 0, 1, 'h67),        4'd12, 1'b0, 4'd11},  // R11 jalr
        '{enc(0, 0, 1, 1, 1, 'h67),        4'd12, 1'b1, 4'd11},  // R11 jalr funct3 001
        '{enc(0, 0, 0, 0, 0, 'h7F),        4'd0,  1'b1, 4'd12},  // R12 unknown opcode
        '{enc(0, 0, 0, 0, 0, 'h57),        4'd0,  1'b1, 4'd12},  // R12 unknown opcode
        '{32'h0000_0000,                   4'd0,  1'b1, 4'd1},   // R1 all zero
        '{enc(0, 0, 1, 3, 2, 'h31),        4'd0,  1'b1, 4'd1},   // R1 low bits 01
        '{enc(0, 0, 1, 3, 2, 'h02),        4'd0,  1'b1, 4'd1}    // R1 low bits 10
    };

    task automatic check(input logic [3:0] ecls, input logic eill, input int req,
                         input string what);
        n_chk++;
        if (class_o !== ecls || illegal_o !== eill) begin
            n_fail++;
            $display("FAIL R%0d %s: actual cls=%0d ill=%b expected cls=%0d ill=%b",
                     req, what, class_o, illegal_o, ecls, eill);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R13 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_ni = 1'b0;
        insn_i = enc(0, 0, 0, 0, 0, 'h7F);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(4'd0, 1'b0, 13, "reset state");   // R13
        rst_ni = 1'b1;

        // table walk: drive at negedge, result visible one negedge later
        for (int i = 0; i < NVEC; i++) begin
            insn_i = VECS[i].insn;
            @(negedge clk);
            check(VECS[i].cls, VECS[i].ill, int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // R13 latency: legal word settles, then an illegal word must not show before the edge
        insn_i = enc(0, 3, 2, 0, 1, 'h33);
        @(negedge clk);
        check(4'd3, 1'b0, 13, "legal word settled");
        insn_i = enc(0, 0, 1, 7, 2, 'h03);
        #1;
        check(4'd3, 1'b0, 13, "held until clock edge");
        @(negedge clk);
        check(4'd1, 1'b1, 13, "updated after one edge");

        // R13 reset mid-run clears the held trap
        rst_ni = 1'b0;
        #1;
        check(4'd0, 1'b0, 13, "asynchronous reset");
        @(negedge clk);
        check(4'd0, 1'b0, 13, "held in reset");
        rst_ni = 1'b1;
        @(negedge clk);
        check(4'd1, 1'b1, 3, "first word after reset");   // R3

        // R9 remaining exact SYSTEM words and a near miss
        insn_i = enc('h08, 2, 0, 0, 0, 'h73);
        @(negedge clk);
        check(4'd7, 1'b0, 9, "supervisor return");
        insn_i = enc('h08, 5, 0, 0, 0, 'h73);
        @(negedge clk);
        check(4'd7, 1'b0, 9, "wait for interrupt");
        insn_i = enc('h08, 3, 0, 0, 0, 'h73);
        @(negedge clk);
        check(4'd7, 1'b1, 9, "undefined system word");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule